// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block moves bytes between memory and peripherals on behalf of four DMA channels whose registers have already been set up. Each channel is loaded with a start address and a byte count, and has a direction, an address step direction, an auto-reload option and a mask bit. When an unmasked channel has a request, the block asks the processor for its buses. Once the processor grants them, the block runs one byte transfer for the highest-priority requesting channel. During that byte it drives the address, the paired memory and I/O strobes and that channel's acknowledge line. It then releases the buses.

The count is loaded as one less than the number of bytes. When the last byte is done, or when an external end input arrives during a byte, the channel records a terminal-count flag and the block pulses an end output. A channel that is not set to auto-reload then stays idle until it is loaded again. An auto-reload channel restores its start address and count and carries on. A low ready input stretches any strobe cycle.

In block-copy mode, channel 0 holds the source pointer and channel 1 the destination pointer. Each byte is a memory read into an internal holding register followed by a memory write. With the source pointer held fixed, one byte value fills the whole destination range.

Top module: `dmae_engine`

## Requirements
- R1: After reset, hrq_o, every strobe, eop_o and tc_o are 0, addr_o is 0, and dack_o shows every channel inactive.
- R2: A channel is eligible when its mask bit is 0 and either its request input is active or its software request bit is 1. Any eligible channel raises hrq_o. A masked channel never raises hrq_o.
- R3: When hlda_i is seen with hrq_o high, the lowest-numbered eligible channel is served (channel 0 has the highest priority).
- R4: A byte runs only while hlda_i is high. For a channel with cfg_mem_read_i=1, mem_rd_o and io_wr_o are driven together. For cfg_mem_read_i=0, io_rd_o and mem_wr_o are driven together. The served channel's dack_o bit is the only active one.
- R5: A count loaded as N gives N+1 bytes. After the last byte, that channel's tc_o bit is set and eop_o is high for exactly one cycle.
- R6: After each byte the current address moves by one: down when cfg_addr_dec_i is 1, up otherwise. The address wraps at the width limit.
- R7: A channel with its tc_o bit set and auto-reload off does not raise hrq_o until a cfg_load_i pulse clears the flag and reloads it.
- R8: With cfg_auto_init_i set, the channel's address and count return to the loaded values after the last byte, and the channel keeps serving requests.
- R9: While ready_i is low, the strobes and addr_o hold, and the address and count do not advance.
- R10: eop_i high in the cycle a byte completes ends the channel exactly as a terminal count does: the tc_o bit is set and eop_o pulses.
- R11: cfg_req_low_i=1 makes dreq_i active-low. cfg_ack_low_i=1 makes dack_o active-low.
- R12: In block-copy mode (cfg_mem2mem_i=1, started by channel 0), each byte is a mem_rd_o cycle at channel 0's address, then a mem_wr_o cycle at channel 1's address that drives the captured byte on mem_wdata_o. No acknowledge is active. Channel 1's count decides the terminal count, which sets tc_o bits 0 and 1.
- R13: In block-copy mode with cfg_src_hold_i=1, channel 0's address stays fixed while channel 1's address advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | NCH | Per-channel pulse: latch start address and count, clear terminal flag |
| cfg_base_addr_i | input | NCH*AW | Start address per channel, channel k at bits [k*AW +: AW] |
| cfg_base_cnt_i | input | NCH*CW | Byte count minus one per channel, channel k at bits [k*CW +: CW] |
| cfg_mem_read_i | input | NCH | 1: memory to I/O; 0: I/O to memory |
| cfg_addr_dec_i | input | NCH | 1: address decrements after each byte |
| cfg_auto_init_i | input | NCH | 1: reload address and count after the last byte |
| cfg_mask_i | input | NCH | 1: channel disabled |
| cfg_mem2mem_i | input | 1 | Block-copy mode on channels 0 and 1 |
| cfg_src_hold_i | input | 1 | Block copy keeps the source address fixed |
| cfg_req_low_i | input | 1 | dreq_i active-low |
| cfg_ack_low_i | input | 1 | dack_o active-low |
| sw_req_i | input | NCH | Software request per channel |
| dreq_i | input | NCH | Hardware request per channel |
| eop_i | input | 1 | External end of transfer, active high |
| ready_i | input | 1 | Low inserts wait cycles |
| hlda_i | input | 1 | Bus grant from the processor |
| mem_rdata_i | input | DW | Memory read data during block copy |
| hrq_o | output | 1 | Bus request to the processor |
| addr_o | output | AW | Transfer address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| mem_wdata_o | output | DW | Captured byte during the block-copy write cycle, 0 otherwise |
| dack_o | output | NCH | Channel acknowledge, polarity per cfg_ack_low_i |
| eop_o | output | 1 | One-cycle pulse after a channel ends |
| tc_o | output | NCH | Sticky terminal-count flag per channel |

## Verification
The bench builds the block with NCH=4, AW=16, DW=8 and CW narrowed to 8. All four channels are present, so priority is checked between the two ends of the order, with channels 0 and 3 requesting together. The 16-bit address lets a decrementing channel cross from 0x2000 down to 0x1FFF. The 8-bit count keeps every terminal-count and reload scenario to a few bytes. Block copy and fill run on the same channel pair, each for three bytes.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_CP_RD,
    ST_CP_WR
  } dmae_state_e;
endpackage

// File: rtl/dmae_prio_arb.sv
module dmae_prio_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic [IW-1:0]  idx_o,
  output logic           any_o
);
  // descending scan: lowest index wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmae_chan.sv
module dmae_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] base_cnt_i,
  input  logic          step_i,
  input  logic          reload_i,
  input  logic          dec_i,
  input  logic          hold_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          cnt_zero_o
);
  logic [AW-1:0] base_addr_q, cur_addr_q;
  logic [CW-1:0] base_cnt_q, cur_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      cur_addr_q  <= base_addr_i;
      cur_cnt_q   <= base_cnt_i;
    end else if (step_i) begin
      if (reload_i) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        if (!hold_i) cur_addr_q <= dec_i ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
        cur_cnt_q <= cur_cnt_q - 1'b1;
      end
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cnt_zero_o = (cur_cnt_q == '0);
endmodule

// File: rtl/dmae_seq.sv
module dmae_seq
  import dmae_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pend_i,
  input  logic [IW-1:0] win_i,
  input  logic        win_any_i,
  input  logic        hlda_i,
  input  logic        ready_i,
  input  logic        cp_en_i,
  output dmae_state_e state_o,
  output logic [IW-1:0] act_o,
  output logic        cp_act_o,
  output logic        done_o,
  output logic        rd_done_o
);
  dmae_state_e state_q;
  logic [IW-1:0] act_q;
  logic cp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      cp_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pend_i) state_q <= ST_REQ;
        ST_REQ: begin
          if (hlda_i) begin
            if (win_any_i) begin
              act_q <= win_i;
              if (cp_en_i && (win_i == '0)) begin
                cp_q    <= 1'b1;
                state_q <= ST_CP_RD;
              end else begin
                state_q <= ST_XFER;
              end
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (!pend_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_XFER:  if (ready_i) state_q <= ST_IDLE;
        ST_CP_RD: if (ready_i) state_q <= ST_CP_WR;
        ST_CP_WR: if (ready_i) begin
          state_q <= ST_IDLE;
          cp_q    <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign act_o     = act_q;
  assign cp_act_o  = cp_q;
  assign done_o    = ready_i && ((state_q == ST_XFER) || (state_q == ST_CP_WR));
  assign rd_done_o = ready_i && (state_q == ST_CP_RD);
endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
  import dmae_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  cfg_load_i,
  input  logic [NCH*AW-1:0] cfg_base_addr_i,
  input  logic [NCH*CW-1:0] cfg_base_cnt_i,
  input  logic [NCH-1:0]  cfg_mem_read_i,
  input  logic [NCH-1:0]  cfg_addr_dec_i,
  input  logic [NCH-1:0]  cfg_auto_init_i,
  input  logic [NCH-1:0]  cfg_mask_i,
  input  logic            cfg_mem2mem_i,
  input  logic            cfg_src_hold_i,
  input  logic            cfg_req_low_i,
  input  logic            cfg_ack_low_i,
  input  logic [NCH-1:0]  sw_req_i,
  input  logic [NCH-1:0]  dreq_i,
  input  logic            eop_i,
  input  logic            ready_i,
  input  logic            hlda_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            hrq_o,
  output logic [AW-1:0]   addr_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            io_rd_o,
  output logic            io_wr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic [NCH-1:0]  dack_o,
  output logic            eop_o,
  output logic [NCH-1:0]  tc_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  dmae_state_e   state;
  logic [IW-1:0] act_idx, win_idx;
  logic          win_any, cp_act, done, rd_done, term;
  logic [NCH-1:0] elig, step, reload, cnt_zero, tc_q;
  logic [AW-1:0] cur_addr [NCH];
  logic [DW-1:0] hold_byte_q;
  logic          eop_q;
  logic [NCH-1:0] req_act;

  assign req_act = dreq_i ^ {NCH{cfg_req_low_i}};

  dmae_prio_arb #(.NCH(NCH)) u_arb (
    .req_i (elig),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  dmae_seq #(.NCH(NCH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (|elig),
    .win_i     (win_idx),
    .win_any_i (win_any),
    .hlda_i    (hlda_i),
    .ready_i   (ready_i),
    .cp_en_i   (cfg_mem2mem_i),
    .state_o   (state),
    .act_o     (act_idx),
    .cp_act_o  (cp_act),
    .done_o    (done),
    .rd_done_o (rd_done)
  );

  // block copy: destination count ends the pair
  assign term = done && (eop_i || (cp_act ? cnt_zero[1] : cnt_zero[act_idx]));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic blocked;
    assign blocked  = (tc_q[k] && !cfg_auto_init_i[k]) || (cfg_mem2mem_i && (k == 1));
    assign elig[k]  = (req_act[k] || sw_req_i[k]) && !cfg_mask_i[k] && !blocked;
    assign step[k]  = done && (cp_act ? (k < 2) : (act_idx == IW'(k)));
    assign reload[k] = step[k] && term && cfg_auto_init_i[k];

    dmae_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (cfg_load_i[k]),
      .base_addr_i (cfg_base_addr_i[k*AW +: AW]),
      .base_cnt_i  (cfg_base_cnt_i[k*CW +: CW]),
      .step_i      (step[k]),
      .reload_i    (reload[k]),
      .dec_i       (cfg_addr_dec_i[k]),
      .hold_i      (cp_act && cfg_src_hold_i && (k == 0)),
      .cur_addr_o  (cur_addr[k]),
      .cnt_zero_o  (cnt_zero[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                tc_q[k] <= 1'b0;
      else if (cfg_load_i[k])     tc_q[k] <= 1'b0;
      else if (step[k] && term)   tc_q[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_byte_q <= '0;
      eop_q       <= 1'b0;
    end else begin
      if (rd_done) hold_byte_q <= mem_rdata_i;
      eop_q <= term;
    end
  end

  logic xfer, dir_rd;
  assign xfer   = (state == ST_XFER);
  assign dir_rd = cfg_mem_read_i[act_idx];

  always_comb begin
    addr_o = '0;
    unique case (state)
      ST_XFER:  addr_o = cur_addr[act_idx];
      ST_CP_RD: addr_o = cur_addr[0];
      ST_CP_WR: addr_o = cur_addr[1];
      default:  addr_o = '0;
    endcase
  end

  assign hrq_o       = (state != ST_IDLE);
  assign mem_rd_o    = (xfer && dir_rd) || (state == ST_CP_RD);
  assign io_wr_o     = xfer && dir_rd;
  assign io_rd_o     = xfer && !dir_rd;
  assign mem_wr_o    = (xfer && !dir_rd) || (state == ST_CP_WR);
  assign mem_wdata_o = (state == ST_CP_WR) ? hold_byte_q : '0;
  assign dack_o      = (xfer ? (NCH'(1) << act_idx) : '0) ^ {NCH{cfg_ack_low_i}};
  assign eop_o       = eop_q;
  assign tc_o        = tc_q;
endmodule

// File: rtl/dmae_chk.sv
module dmae_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hlda_i,
  input logic           ready_i,
  input logic           cfg_ack_low_i,
  input logic           hrq_o,
  input logic [AW-1:0]  addr_o,
  input logic           mem_rd_o,
  input logic           mem_wr_o,
  input logic           io_rd_o,
  input logic           io_wr_o,
  input logic [NCH-1:0] dack_o,
  input logic           eop_o
);
  logic any_strb;
  assign any_strb = mem_rd_o || mem_wr_o;

  a_r4_read_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |-> (mem_rd_o && !mem_wr_o && !io_rd_o));

  a_r4_write_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_o |-> (mem_wr_o && !mem_rd_o && !io_wr_o));

  a_r4_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strb |-> (hlda_i && hrq_o));

  a_r4_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o ^ {NCH{cfg_ack_low_i}}));

  a_r9_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strb && !ready_i) |=> ($stable(addr_o) && $stable(mem_rd_o) && $stable(mem_wr_o)
                                && $stable(io_rd_o) && $stable(io_wr_o)));

  a_r5_eop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);

  a_r12_copy_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strb && !io_rd_o && !io_wr_o) |-> ((dack_o ^ {NCH{cfg_ack_low_i}}) == '0));
endmodule

bind dmae_engine dmae_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hlda_i        (hlda_i),
  .ready_i       (ready_i),
  .cfg_ack_low_i (cfg_ack_low_i),
  .hrq_o         (hrq_o),
  .addr_o        (addr_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .io_rd_o       (io_rd_o),
  .io_wr_o       (io_wr_o),
  .dack_o        (dack_o),
  .eop_o         (eop_o)
);

// File: tb/tb_dmae_engine.sv
module tb_dmae_engine;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 8;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0]    cfg_load_i = '0;
  logic [NCH*AW-1:0] cfg_base_addr_i = '0;
  logic [NCH*CW-1:0] cfg_base_cnt_i = '0;
  logic [NCH-1:0]    cfg_mem_read_i = '0, cfg_addr_dec_i = '0, cfg_auto_init_i = '0;
  logic [NCH-1:0]    cfg_mask_i = '1, sw_req_i = '0, dreq_i = '0;
  logic cfg_mem2mem_i = 0, cfg_src_hold_i = 0, cfg_req_low_i = 0, cfg_ack_low_i = 0;
  logic eop_i = 0, ready_i = 1, hlda_i = 0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic hrq_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, eop_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [NCH-1:0] dack_o, tc_o;

  int n_chk = 0, n_err = 0;

  dmae_engine #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .cfg_base_addr_i(cfg_base_addr_i),
    .cfg_base_cnt_i(cfg_base_cnt_i), .cfg_mem_read_i(cfg_mem_read_i), .cfg_addr_dec_i(cfg_addr_dec_i),
    .cfg_auto_init_i(cfg_auto_init_i), .cfg_mask_i(cfg_mask_i), .cfg_mem2mem_i(cfg_mem2mem_i),
    .cfg_src_hold_i(cfg_src_hold_i), .cfg_req_low_i(cfg_req_low_i), .cfg_ack_low_i(cfg_ack_low_i),
    .sw_req_i(sw_req_i), .dreq_i(dreq_i), .eop_i(eop_i), .ready_i(ready_i), .hlda_i(hlda_i),
    .mem_rdata_i(mem_rdata_i), .hrq_o(hrq_o), .addr_o(addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .mem_wdata_o(mem_wdata_o),
    .dack_o(dack_o), .eop_o(eop_o), .tc_o(tc_o)
  );

  function automatic logic [3:0] strb();
    return {mem_rd_o, mem_wr_o, io_rd_o, io_wr_o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_ch(input int ch, input logic [AW-1:0] a, input logic [CW-1:0] c,
                         input bit rd, input bit dec, input bit ai);
    cfg_base_addr_i[ch*AW +: AW] = a;
    cfg_base_cnt_i[ch*CW +: CW]  = c;
    cfg_mem_read_i[ch]  = rd;
    cfg_addr_dec_i[ch]  = dec;
    cfg_auto_init_i[ch] = ai;
    cfg_load_i[ch] = 1'b1;
    @(negedge clk);
    cfg_load_i[ch] = 1'b0;
  endtask

  task automatic wait_hrq(input string req);
    for (int i = 0; i < 20 && !hrq_o; i++) @(negedge clk);
    check(hrq_o, req, hrq_o, 1);
  endtask

  task automatic expect_quiet(input string req);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(!hrq_o, req, hrq_o, 0);
  endtask

  task automatic run_byte(input int waits, input bit eop_in, output logic [AW-1:0] a,
                          output logic [3:0] s, output logic [NCH-1:0] dk, output logic e);
    wait_hrq("R2");
    hlda_i  = 1'b1;
    ready_i = (waits == 0);
    @(negedge clk);
    a = addr_o; s = strb(); dk = dack_o;
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      check(addr_o == a && strb() == s, "R9", {addr_o, 12'h0, strb()}, {a, 12'h0, s});
    end
    ready_i = 1'b1;
    eop_i   = eop_in;
    @(negedge clk);
    e = eop_o;
    hlda_i = 1'b0;
    eop_i  = 1'b0;
  endtask

  task automatic copy_byte(input logic [DW-1:0] rd, output logic [AW-1:0] ra, output logic [AW-1:0] wa,
                           output logic [DW-1:0] wd, output logic [7:0] ss, output logic e);
    wait_hrq("R12");
    hlda_i = 1'b1; ready_i = 1'b1;
    @(negedge clk);
    ra = addr_o; ss[7:4] = strb(); mem_rdata_i = rd;
    check(dack_o == '0, "R12", dack_o, 0);
    @(negedge clk);
    wa = addr_o; ss[3:0] = strb(); wd = mem_wdata_o;
    @(negedge clk);
    e = eop_o;
    hlda_i = 1'b0;
  endtask

  task automatic t_reset();
    check(!hrq_o && strb() == 0 && !eop_o && tc_o == 0 && addr_o == 0 && dack_o == 0,
          "R1", {hrq_o, strb(), eop_o, tc_o}, 0);
  endtask

  task automatic t_mask_and_read();
    logic [AW-1:0] a; logic [3:0] s; logic [NCH-1:0] dk; logic e;
    load_ch(1, 16'h1000, 8'd2, 1, 0, 0);
    load_ch(2, 16'h0040, 8'd9, 1, 0, 0);
    dreq_i[2] = 1'b1;
    expect_quiet("R2 masked");
    dreq_i[2] = 1'b0;
    cfg_mask_i[1] = 1'b0; dreq_i[1] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      run_byte(0, 0, a, s, dk, e);
      check(a == 16'h1000 + i, "R6 inc", a, 16'h1000 + i);
      check(s == 4'b1001 && dk == 4'b0010, "R4 read", {s, dk}, {4'b1001, 4'b0010});
      check(e == (i == 2), "R5 eop", e, i == 2);
    end
    check(tc_o[1], "R5 tc", tc_o, 4'b0010);
    @(negedge clk);
    check(!eop_o, "R5 pulse", eop_o, 0);
    expect_quiet("R7");
    dreq_i[1] = 1'b0; cfg_mask_i = '1;
  endtask

  task automatic t_prio_autoinit();
    logic [AW-1:0] a; logic [3:0] s; logic [NCH-1:0] dk; logic e;
    load_ch(0, 16'h2000, 8'd1, 0, 1, 0);
    load_ch(3, 16'h3000, 8'd1, 1, 0, 1);
    cfg_mask_i[0] = 0; cfg_mask_i[3] = 0; dreq_i[0] = 1; dreq_i[3] = 1;
    run_byte(0, 0, a, s, dk, e);
    check(dk == 4'b0001 && a == 16'h2000, "R3", {a, dk}, {16'h2000, 4'b0001});
    check(s == 4'b0110, "R4 write", s, 4'b0110);
    run_byte(0, 0, a, s, dk, e);
    check(a == 16'h1FFF && e, "R6 dec", {a, 3'b0, e}, {16'h1FFF, 4'b0001});
    for (int i = 0; i < 3; i++) begin
      run_byte(0, 0, a, s, dk, e);
      check(dk == 4'b1000 && a == ((i == 1) ? 16'h3001 : 16'h3000), "R8",
            {a, dk}, {((i == 1) ? 16'h3001 : 16'h3000), 4'b1000});
    end
    check(tc_o[3], "R8 tc", tc_o, 4'b1001);
    dreq_i = '0; cfg_mask_i = '1;
    @(negedge clk);
  endtask

  task automatic t_wait_eop();
    logic [AW-1:0] a; logic [3:0] s; logic [NCH-1:0] dk; logic e;
    cfg_mask_i[2] = 0; dreq_i[2] = 1;
    run_byte(2, 0, a, s, dk, e);
    check(a == 16'h0040 && !e, "R9", {a, 3'b0, e}, 16'h0040);
    run_byte(0, 1, a, s, dk, e);
    check(a == 16'h0041, "R9 no step", a, 16'h0041);
    check(e && tc_o[2], "R10", {e, tc_o}, 5'b10100);
    expect_quiet("R10 ends");
    dreq_i[2] = 0;
    load_ch(2, 16'h0080, 8'd0, 1, 0, 0);
    sw_req_i[2] = 1;
    run_byte(0, 0, a, s, dk, e);
    check(a == 16'h0080 && dk == 4'b0100 && e, "R2 sw", {a, dk}, {16'h0080, 4'b0100});
    sw_req_i[2] = 0; cfg_mask_i = '1;
    @(negedge clk);
  endtask

  task automatic t_polarity();
    logic [AW-1:0] a; logic [3:0] s; logic [NCH-1:0] dk; logic e;
    cfg_req_low_i = 1; cfg_ack_low_i = 1; dreq_i = '1;
    load_ch(1, 16'h0100, 8'd0, 0, 0, 0);
    cfg_mask_i[1] = 0;
    check(dack_o == 4'b1111, "R11 idle", dack_o, 4'b1111);
    expect_quiet("R11 high idle");
    dreq_i[1] = 0;
    run_byte(0, 0, a, s, dk, e);
    check(dk == 4'b1101 && a == 16'h0100, "R11", {a, dk}, {16'h0100, 4'b1101});
    dreq_i = '1; cfg_mask_i = '1;
    @(negedge clk);
    cfg_req_low_i = 0; cfg_ack_low_i = 0; dreq_i = '0;
    @(negedge clk);
  endtask

  task automatic t_copy(input bit hold);
    logic [AW-1:0] ra, wa; logic [DW-1:0] wd; logic [7:0] ss; logic e;
    logic [AW-1:0] exp_ra;
    load_ch(0, 16'h4000, 8'd2, 0, 0, 0);
    load_ch(1, 16'h5000, 8'd2, 0, 0, 0);
    cfg_mem2mem_i = 1; cfg_src_hold_i = hold;
    cfg_mask_i[0] = 0; cfg_mask_i[1] = 0; sw_req_i[0] = 1;
    for (int i = 0; i < 3; i++) begin
      copy_byte(8'hA0 + 8'(i), ra, wa, wd, ss, e);
      exp_ra = hold ? 16'h4000 : 16'h4000 + 16'(i);
      check(ra == exp_ra, hold ? "R13" : "R12 src", ra, exp_ra);
      check(wa == 16'h5000 + 16'(i) && wd == 8'hA0 + 8'(i), "R12 dst", {wa, wd}, {16'h5000 + 16'(i), 8'hA0 + 8'(i)});
      check(ss == 8'b1000_0100, "R12 strb", ss, 8'b1000_0100);
      check(e == (i == 2), "R12 eop", e, i == 2);
    end
    check(tc_o[1:0] == 2'b11, "R12 tc", tc_o, 2'b11);
    expect_quiet("R12 done");
    sw_req_i = '0; cfg_mask_i = '1; cfg_mem2mem_i = 0; cfg_src_hold_i = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_mask_and_read();
    t_prio_autoinit();
    t_wait_eop();
    t_polarity();
    t_copy(0);
    t_copy(1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule